// File: doc/BRIEF.md
# Recency-Tracking Victim Selector

This block keeps a short move-to-front list of the page frames that were referenced most recently and, on request, names a replacement victim taken from the frames that are not on that list. Each cycle the memory manager may present one frame-number reference. The frame goes to the top of the list. A frame that is already listed is lifted out of its old slot, so no frame is ever listed twice. When a new frame arrives and the list is full, the oldest entry falls off the bottom.

A victim request starts a scan. The scan begins at a pseudo-random frame number, taken from a free-running 16-bit linear feedback shift register reduced modulo the frame count. It walks upward through the frame numbers, wrapping around at the end, and stops at the first frame that is not listed. The result appears a fixed two clock edges after the request. If every physical frame is on the list, which can only happen when the frame count does not exceed the list depth, the bottom entry is returned instead. A synchronous clear empties the list and drops any victim request still in flight.

Top module: `frame_recency_stack`

## Requirements
- R1: After reset, and until the first request has been served, vic_vld is low and the list is empty.
- R2: A vic_req sampled high at clock edge e makes vic_vld high for exactly one cycle, the cycle after edge e+1. It does so unless clr or rst is high at edge e or edge e+1. At all other times vic_vld is low.
- R3: If at least one frame is not on the list when the scan runs, the returned vic_frame is not on the list.
- R4: A reference to a frame that is already listed moves it to the top. The entries that were above it move down by one slot, and the frame is not duplicated.
- R5: A reference to an unlisted frame while the list holds D entries drops the bottom (least recent) entry, and the dropped frame becomes eligible as a victim.
- R6: When all NF frames are listed, the victim is the bottom entry, which is the least recently referenced frame.
- R7: A reference and a victim request in the same cycle are applied reference first, so that frame is never returned by that request.
- R8: Successive requests on an unchanged list do not all return the same frame, because the scan start comes from a free-running pseudo-random register.
- R9: clr high at an edge empties the list, and frames referenced before the clear become eligible victims again. It also ignores a reference in the same cycle and cancels any request that has not yet been answered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of the list and of pending requests |
| ref_vld | input | 1 | A frame reference is present this cycle |
| ref_frame | input | $clog2(NF) | Referenced frame number, below NF |
| vic_req | input | 1 | Request one victim frame |
| vic_vld | output | 1 | vic_frame holds an answer this cycle |
| vic_frame | output | $clog2(NF) | Chosen victim frame number |

## Verification
The assertions assume that ref_frame is below NF whenever ref_vld is high, and that rst stays high for at least two edges, so that every past value they inspect comes from a defined cycle. The stimulus draws frame numbers from a window that fits inside the frame count. The window is slightly wider than the list, so hits, misses and bottom drops all occur, and the stimulus asserts reset for four cycles before any traffic. Requests, references and clears are mixed freely, including in the same cycle, because the block defines an order for each of those combinations.

// File: rtl/frs_pkg.sv
package frs_pkg;

    localparam int              LFSR_W    = 16;
    localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;
    localparam logic [LFSR_W-1:0] LFSR_MASK = 16'hB400;

    // one step of a maximal-length Galois shift register
    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
        if (s[0]) return (s >> 1) ^ LFSR_MASK;
        return s >> 1;
    endfunction

    function automatic int frame_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/frs_lfsr.sv
module frs_lfsr
    import frs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    output logic [LFSR_W-1:0] state
);
    always_ff @(posedge clk) begin
        if (rst) state <= LFSR_SEED;
        else     state <= lfsr_step(state);
    end
endmodule

// File: rtl/frs_stack.sv
module frs_stack #(
    parameter int NF = 64,
    parameter int D  = 16,
    parameter int FW = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  logic                 ref_vld,
    input  logic [FW-1:0]        ref_frame,
    output logic [D-1:0]         ent_vld,
    output logic [D-1:0][FW-1:0] ent_frame,
    output logic [NF-1:0]        member,
    output logic [FW-1:0]        bottom
);
    logic [D-1:0] hit;
    logic [D-1:0] hold;   // a hit sits strictly above this slot

    always_comb begin
        for (int i = 0; i < D; i++)
            hit[i] = ent_vld[i] && (ent_frame[i] == ref_frame);
    end

    always_comb begin
        hold[0] = 1'b0;
        for (int i = 1; i < D; i++)
            hold[i] = hold[i-1] | hit[i-1];
    end

    // top slot takes the reference; slots down to the old position shift
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ent_vld   <= '0;
            ent_frame <= '0;
        end else if (ref_vld) begin
            ent_vld[0]   <= 1'b1;
            ent_frame[0] <= ref_frame;
            for (int i = 1; i < D; i++) begin
                if (!hold[i]) begin
                    ent_vld[i]   <= ent_vld[i-1];
                    ent_frame[i] <= ent_frame[i-1];
                end
            end
        end
    end

    // per-frame presence vector
    for (genvar gf = 0; gf < NF; gf++) begin : g_frame
        logic [D-1:0] match;
        for (genvar gd = 0; gd < D; gd++) begin : g_slot
            assign match[gd] = ent_vld[gd] && (ent_frame[gd] == FW'(gf));
        end
        assign member[gf] = |match;
    end

    assign bottom = ent_frame[D-1];
endmodule

// File: rtl/frs_pick.sv
module frs_pick #(
    parameter int NF = 64,
    parameter int FW = 6
) (
    input  logic [NF-1:0] member,
    input  logic [FW-1:0] start,
    input  logic [FW-1:0] bottom,
    output logic [FW-1:0] pick,
    output logic          none_free
);
    // circular first-free search starting at 'start'
    always_comb begin
        pick      = bottom;
        none_free = 1'b1;
        for (int k = NF - 1; k >= 0; k--) begin
            logic [FW-1:0] jj;
            jj = FW'((int'(start) + k) % NF);
            if (!member[jj]) begin
                pick      = jj;
                none_free = 1'b0;
            end
        end
    end
endmodule

// File: rtl/frame_recency_stack.sv
module frame_recency_stack
    import frs_pkg::*;
#(
    parameter int  NF = 64,
    parameter int  D  = 16,
    localparam int FW = frame_bits(NF)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          ref_vld,
    input  logic [FW-1:0] ref_frame,
    input  logic          vic_req,
    output logic          vic_vld,
    output logic [FW-1:0] vic_frame
);
    typedef struct packed {
        logic          vld;
        logic [FW-1:0] frame;
    } vic_t;

    localparam logic [LFSR_W-1:0] NF_L = LFSR_W'(NF);

    logic [LFSR_W-1:0]    lfsr_q;
    logic [LFSR_W-1:0]    start_full;
    logic [FW-1:0]        scan_start;
    logic [D-1:0]         stk_vld;
    logic [D-1:0][FW-1:0] stk_frame;
    logic [NF-1:0]        stk_member;
    logic [FW-1:0]        stk_bottom;
    logic [FW-1:0]        pick_frame;
    logic                 pick_none;
    logic                 req_q;
    vic_t                 vic_q;

    frs_lfsr u_lfsr (
        .clk   (clk),
        .rst   (rst),
        .state (lfsr_q)
    );

    frs_stack #(.NF(NF), .D(D), .FW(FW)) u_stack (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr),
        .ref_vld   (ref_vld),
        .ref_frame (ref_frame),
        .ent_vld   (stk_vld),
        .ent_frame (stk_frame),
        .member    (stk_member),
        .bottom    (stk_bottom)
    );

    assign start_full = lfsr_q % NF_L;
    assign scan_start = start_full[FW-1:0];

    frs_pick #(.NF(NF), .FW(FW)) u_pick (
        .member    (stk_member),
        .start     (scan_start),
        .bottom    (stk_bottom),
        .pick      (pick_frame),
        .none_free (pick_none)
    );

    // request is registered so the scan sees the list after a same-cycle reference
    always_ff @(posedge clk) begin
        if (rst || clr) req_q <= 1'b0;
        else            req_q <= vic_req;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            vic_q <= '0;
        end else begin
            vic_q.vld <= req_q;
            if (req_q) vic_q.frame <= pick_frame;
        end
    end

    assign vic_vld   = vic_q.vld;
    assign vic_frame = vic_q.frame;
endmodule

// File: rtl/frs_checker.sv
module frs_checker #(
    parameter int NF = 64,
    parameter int D  = 16,
    parameter int FW = 6
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 clr,
    input logic                 ref_vld,
    input logic [FW-1:0]        ref_frame,
    input logic                 vic_req,
    input logic                 vic_vld,
    input logic [FW-1:0]        vic_frame,
    input logic [D-1:0]         ent_vld,
    input logic [D-1:0][FW-1:0] ent_frame,
    input logic [NF-1:0]        member,
    input logic [FW-1:0]        bottom,
    input logic                 none_free
);
    logic [NF-1:0] mem_q;
    logic          none_q;
    logic [FW-1:0] bot_q;

    always_ff @(posedge clk) begin
        mem_q  <= member;
        none_q <= none_free;
        bot_q  <= bottom;
    end

    a_r1_reset_empty: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!vic_vld && ent_vld == '0));

    a_r2_vld_needs_req: assert property (@(posedge clk) disable iff (rst)
        vic_vld |-> $past(vic_req, 2));

    a_r2_req_answered: assert property (@(posedge clk) disable iff (rst)
        ($past(vic_req, 2) && !$past(clr, 2) && !$past(clr, 1)
         && !$past(rst, 2) && !$past(rst, 1)) |-> vic_vld);

    a_r3_victim_unlisted: assert property (@(posedge clk) disable iff (rst)
        (vic_vld && !none_q) |-> !mem_q[vic_frame]);

    a_r4_no_duplicate: assert property (@(posedge clk) disable iff (rst)
        $countones(ent_vld) == $countones(member));

    a_r5_fill_from_top: assert property (@(posedge clk) disable iff (rst)
        (ent_vld & (ent_vld + D'(1))) == '0);

    a_r6_fallback_bottom: assert property (@(posedge clk) disable iff (rst)
        (vic_vld && none_q) |-> (vic_frame == bot_q));

    a_r7_ref_on_top: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ref_vld) && !$past(clr))
        |-> (ent_vld[0] && ent_frame[0] == $past(ref_frame)));

    a_r9_clear_empties: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(clr)) |-> (ent_vld == '0 && !vic_vld));
endmodule

bind frame_recency_stack frs_checker #(.NF(NF), .D(D), .FW(FW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .clr       (clr),
    .ref_vld   (ref_vld),
    .ref_frame (ref_frame),
    .vic_req   (vic_req),
    .vic_vld   (vic_vld),
    .vic_frame (vic_frame),
    .ent_vld   (stk_vld),
    .ent_frame (stk_frame),
    .member    (stk_member),
    .bottom    (stk_bottom),
    .none_free (pick_none)
);

// File: tb/frame_recency_stack_tb.sv
`timescale 1ns/1ps
module frame_recency_stack_tb;

    localparam int NF = 64;
    localparam int D  = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       clr = 1'b0;
    logic       ref_vld = 1'b0;
    logic [5:0] ref_frame = '0;
    logic       vic_req = 1'b0;
    logic       vic_vld;
    logic [5:0] vic_frame;
    logic       s_vld;
    logic [2:0] s_frame;

    int nchk = 0;
    int nfail = 0;

    always #2.5 clk = ~clk;

    frame_recency_stack #(.NF(NF), .D(D)) u_dut (
        .clk(clk), .rst(rst), .clr(clr), .ref_vld(ref_vld), .ref_frame(ref_frame),
        .vic_req(vic_req), .vic_vld(vic_vld), .vic_frame(vic_frame)
    );

    frame_recency_stack #(.NF(8), .D(8)) u_dut_small (
        .clk(clk), .rst(rst), .clr(clr), .ref_vld(ref_vld), .ref_frame(ref_frame[2:0]),
        .vic_req(vic_req), .vic_vld(s_vld), .vic_frame(s_frame)
    );

    // reference model of the large instance's list
    int          m_fr [D];
    int          m_n = 0;
    logic [63:0] s1_set = '0;
    bit          s1_v = 1'b0;
    bit          got = 1'b0;
    int          last_vic = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic m_ref(input int f);
        int pos = -1;
        for (int i = 0; i < m_n; i++) if (m_fr[i] == f) pos = i;
        if (pos < 0) begin
            if (m_n < D) m_n++;
            pos = m_n - 1;
        end
        for (int i = pos; i > 0; i--) m_fr[i] = m_fr[i-1];
        m_fr[0] = f;
    endtask

    function automatic logic [63:0] m_set();
        logic [63:0] s = '0;
        for (int i = 0; i < m_n; i++) s[m_fr[i]] = 1'b1;
        return s;
    endfunction

    task automatic tick(input bit r, input int f, input bit q, input bit c);
        bit          o_v;
        logic [63:0] o_set;
        ref_vld   = r;
        ref_frame = 6'(f);
        vic_req   = q;
        clr       = c;
        @(posedge clk);
        if (c) m_n = 0;
        else if (r) m_ref(f);
        o_v   = s1_v && !c;
        o_set = s1_set;
        s1_v  = q && !c;
        s1_set = m_set();
        @(negedge clk);
        check(vic_vld == o_v, "R2 vic_vld timing", int'(vic_vld), int'(o_v));
        got = o_v && vic_vld;
        if (got) begin
            last_vic = int'(vic_frame);
            check(!o_set[vic_frame], "R3 victim not listed", last_vic, -1);
        end
    endtask

    task automatic chk_small(input int exp, input string req);
        check(s_vld == 1'b1, req, int'(s_vld), 1);
        check(int'(s_frame) == exp, req, int'(s_frame), exp);
    endtask

    initial begin
        int          low;
        logic [63:0] seen;
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(vic_vld == 1'b0, "R1 reset vld", int'(vic_vld), 0);
        check(s_vld == 1'b0, "R1 reset vld small", int'(s_vld), 0);
        tick(0, 0, 0, 0);
        check(vic_vld == 1'b0, "R1 idle after reset", int'(vic_vld), 0);

        // R6: small instance, all eight frames listed, bottom is frame 0
        for (int f = 0; f < 8; f++) tick(1, f, 0, 0);
        tick(0, 0, 1, 0);
        tick(0, 0, 0, 0);
        chk_small(0, "R6 fallback bottom");

        // R7 and R4: reference 0 with request, 0 lifts to top, bottom becomes 1
        tick(1, 0, 1, 0);
        tick(0, 0, 0, 0);
        chk_small(1, "R7 reference before request");

        // R4: repeated reference creates no duplicate, bottom stays 1
        repeat (5) tick(1, 7, 0, 0);
        tick(0, 0, 1, 0);
        tick(0, 0, 0, 0);
        chk_small(1, "R4 no duplicate");

        // R9: clear cancels an outstanding request
        tick(0, 0, 1, 0);
        tick(0, 0, 0, 1);
        check(s_vld == 1'b0, "R9 pending cancelled", int'(s_vld), 0);
        tick(0, 0, 0, 0);
        check(s_vld == 1'b0, "R9 pending cancelled later", int'(s_vld), 0);
        check(vic_vld == 1'b0, "R9 pending cancelled large", int'(vic_vld), 0);

        // R9: frames listed before a clear become eligible again
        for (int f = 0; f < 16; f++) tick(1, f, 0, 0);
        tick(0, 0, 0, 1);
        low = 0;
        repeat (40) begin
            tick(0, 0, 1, 0);
            if (got && last_vic < 16) low++;
        end
        tick(0, 0, 0, 0);
        if (got && last_vic < 16) low++;
        check(low > 0, "R9 cleared frames eligible", low, 1);

        // R5: twenty distinct frames, 0..3 fall off the bottom
        tick(0, 0, 0, 1);
        for (int f = 0; f < 20; f++) tick(1, f, 0, 0);
        low = 0;
        repeat (40) begin
            tick(0, 0, 1, 0);
            if (got && last_vic < 4) low++;
        end
        tick(0, 0, 0, 0);
        if (got && last_vic < 4) low++;
        check(low > 0, "R5 dropped frames eligible", low, 1);

        // R8: unchanged list, victims vary
        seen = '0;
        repeat (20) begin
            tick(0, 0, 1, 0);
            if (got) seen[last_vic] = 1'b1;
        end
        tick(0, 0, 0, 0);
        if (got) seen[last_vic] = 1'b1;
        check($countones(seen) >= 2, "R8 victims vary", $countones(seen), 2);

        // constrained random traffic against the model (R2, R3, R4, R5, R7, R9)
        repeat (3000) begin
            tick(($urandom % 4) != 0, int'($urandom % 24),
                 ($urandom % 3) == 0, ($urandom % 200) == 0);
        end
        tick(0, 0, 0, 0);
        tick(0, 0, 0, 0);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        nfail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule